// File: doc/BRIEF.md
# Two-Tier Daisy-Chain Bus Arbiter

This block decides which device may drive a shared bus. Devices sit in tiers. Each tier reports one merged request to the arbiter, which only learns that some device in the tier wants the bus and not which one. The arbiter picks the most important tier with a pending request and asserts that tier's grant line. The line ripples through the tier's devices in chain order. The first requesting device on the chain keeps the grant and blocks it from every device further down.

Ownership is held without preemption. The owner keeps the bus until it pulses its done input. The grant is then withdrawn, and the next arbitration round begins only after that withdrawal. Tier 0 is the most important tier, and chain position 0 is the device nearest the arbiter. Device index d = tier * CHAIN_LEN + position.

Top module: `tiered_chain_arbiter`

## Requirements
- R1: While reset is held, and after it is released, gnt_o is all zeros and busy_o is 0 until a request is seen.
- R2: At most one bit of gnt_o is 1 in any cycle.
- R3: When devices in different tiers request in the same cycle, the bus goes to a device in the lowest-numbered requesting tier, whatever the chain positions are.
- R4: When several devices in the chosen tier request, the device with the lowest chain position wins.
- R5: While a device holds the grant and has not pulsed done, gnt_o does not change, even when more important tiers or chain positions start requesting.
- R6: A done pulse from the owner clears gnt_o at the next clock edge. A new grant appears no earlier than the edge after that, so busy_o stays 0 for at least one cycle between owners.
- R7: A done pulse from a device that does not hold the grant has no effect on gnt_o.
- R8: When the bus is free and a request is present, a grant appears at the next clock edge.
- R9: busy_o is 1 exactly when some bit of gnt_o is 1.
- R10: A tier-0 device that requests again after every release keeps a tier-1 requester waiting indefinitely. The tier-1 device is granted once tier 0 stops requesting.
- R11: A device is granted only if its request bit was 1 in the cycle before the grant appeared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NUM_TIERS*CHAIN_LEN | Per-device request, held until granted |
| done_i | input | NUM_TIERS*CHAIN_LEN | Per-device completion pulse |
| gnt_o | output | NUM_TIERS*CHAIN_LEN | Per-device grant, one-hot or zero |
| busy_o | output | 1 | Bus is owned |

## Verification
A corrupted owner register would show at the ports in the same cycle: either two grant bits at once or a grant that changes without a done pulse. A wrong tier or chain priority would show one edge after a request, because the grant would go to the wrong index. A fault in the release path would show as a grant that stays after the owner's done pulse, or as a new owner appearing with no free cycle in between. Continuous tier-0 traffic is used to confirm that starving tier 1 is the intended behaviour.

// File: rtl/tca_pkg.sv
package tca_pkg;
  typedef enum logic {
    ST_FREE  = 1'b0,
    ST_OWNED = 1'b1
  } arb_state_e;
endpackage

// File: rtl/tca_rst_sync.sv
module tca_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tca_tier_merge.sv
module tca_tier_merge #(
  parameter int NUM_TIERS = 2,
  parameter int CHAIN_LEN = 4
) (
  input  logic [NUM_TIERS*CHAIN_LEN-1:0] req_i,
  output logic [NUM_TIERS-1:0]           tier_req_o
);
  for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
    assign tier_req_o[t] = |req_i[t*CHAIN_LEN +: CHAIN_LEN];
  end
endmodule

// File: rtl/tca_tier_pick.sv
module tca_tier_pick #(
  parameter int NUM_TIERS = 2,
  localparam int TIER_W = (NUM_TIERS > 1) ? $clog2(NUM_TIERS) : 1
) (
  input  logic [NUM_TIERS-1:0] tier_req_i,
  output logic                 any_o,
  output logic [NUM_TIERS-1:0] pick_oh_o,
  output logic [TIER_W-1:0]    pick_idx_o
);
  always_comb begin
    pick_oh_o  = '0;
    pick_idx_o = '0;
    for (int t = NUM_TIERS - 1; t >= 0; t--) begin
      if (tier_req_i[t]) begin
        pick_oh_o     = '0;
        pick_oh_o[t]  = 1'b1;
        pick_idx_o    = TIER_W'(t);
      end
    end
  end

  assign any_o = |tier_req_i;

  always_comb begin
    AST_PICK_ONEHOT: assert ($onehot0(pick_oh_o)); // R3
  end
endmodule

// File: rtl/tca_grant_chain.sv
module tca_grant_chain #(
  parameter int CHAIN_LEN = 4
) (
  input  logic                 gnt_in_i,
  input  logic [CHAIN_LEN-1:0] req_i,
  output logic [CHAIN_LEN-1:0] take_o,
  output logic                 gnt_out_o
);
  logic [CHAIN_LEN:0] pass;

  assign pass[0] = gnt_in_i;
  for (genvar p = 0; p < CHAIN_LEN; p++) begin : g_link
    assign take_o[p]   = pass[p] & req_i[p];
    assign pass[p + 1] = pass[p] & ~req_i[p];
  end
  assign gnt_out_o = pass[CHAIN_LEN];

  always_comb begin
    AST_CHAIN_SINGLE: assert ($onehot0(take_o)); // R4
  end
endmodule

// File: rtl/tiered_chain_arbiter.sv
module tiered_chain_arbiter
  import tca_pkg::*;
#(
  parameter int NUM_TIERS = 2,
  parameter int CHAIN_LEN = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_TIERS*CHAIN_LEN-1:0] req_i,
  input  logic [NUM_TIERS*CHAIN_LEN-1:0] done_i,
  output logic [NUM_TIERS*CHAIN_LEN-1:0] gnt_o,
  output logic                           busy_o
);
  localparam int NDEV   = NUM_TIERS * CHAIN_LEN;
  localparam int TIER_W = (NUM_TIERS > 1) ? $clog2(NUM_TIERS) : 1;

  logic                 rst_q_n;
  logic [NUM_TIERS-1:0] tier_req;
  logic [NUM_TIERS-1:0] pick_oh;
  logic [TIER_W-1:0]    pick_idx;
  logic                 any_req;
  logic [NUM_TIERS-1:0] tier_line;
  logic [NUM_TIERS-1:0] tier_tail;
  logic [NDEV-1:0]      take_all;
  logic [NUM_TIERS-1:0] tier_hit;
  logic                 release_ev;
  logic                 gnt_en;

  arb_state_e        state_q, state_d;
  logic [NDEV-1:0]   gnt_q, gnt_d;
  logic [TIER_W-1:0] tier_q, tier_d;

  tca_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_q_n)
  );

  tca_tier_merge #(.NUM_TIERS(NUM_TIERS), .CHAIN_LEN(CHAIN_LEN)) i_merge (
    .req_i     (req_i),
    .tier_req_o(tier_req)
  );

  tca_tier_pick #(.NUM_TIERS(NUM_TIERS)) i_pick (
    .tier_req_i(tier_req),
    .any_o     (any_req),
    .pick_oh_o (pick_oh),
    .pick_idx_o(pick_idx)
  );

  // A tier's grant line is driven only while the bus is free.
  assign tier_line = (state_q == ST_FREE) ? pick_oh : '0;

  for (genvar t = 0; t < NUM_TIERS; t++) begin : g_chain
    tca_grant_chain #(.CHAIN_LEN(CHAIN_LEN)) i_chain (
      .gnt_in_i (tier_line[t]),
      .req_i    (req_i[t*CHAIN_LEN +: CHAIN_LEN]),
      .take_o   (take_all[t*CHAIN_LEN +: CHAIN_LEN]),
      .gnt_out_o(tier_tail[t])
    );
    assign tier_hit[t] = |(done_i[t*CHAIN_LEN +: CHAIN_LEN] &
                           gnt_q[t*CHAIN_LEN +: CHAIN_LEN]);
  end

  // Only a done pulse from the owner, inside the owning tier, releases the bus.
  assign release_ev = (state_q == ST_OWNED) & tier_hit[tier_q];

  always_comb begin
    state_d = state_q;
    gnt_d   = gnt_q;
    tier_d  = tier_q;
    unique case (state_q)
      ST_FREE: begin
        if (any_req) begin
          state_d = ST_OWNED;
          gnt_d   = take_all;
          tier_d  = pick_idx;
        end
      end
      ST_OWNED: begin
        if (release_ev) begin
          state_d = ST_FREE;
          gnt_d   = '0;
        end
      end
      default: state_d = ST_FREE;
    endcase
  end

  assign gnt_en = ((state_q == ST_FREE) & any_req) | release_ev;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_FREE;
      gnt_q   <= '0;
      tier_q  <= '0;
    end else if (gnt_en) begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
      tier_q  <= tier_d;
    end
  end

  assign gnt_o  = gnt_q;
  assign busy_o = (state_q == ST_OWNED);

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(gnt_o)); // R2
  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_q_n)
    busy_o == (|gnt_o)); // R9
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_o && ((done_i & gnt_o) == '0)) |=> $stable(gnt_o)); // R5
  AST_OWNER_RELEASE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_o && ((done_i & gnt_o) != '0)) |=> (gnt_o == '0)); // R6
  AST_FREE_GRANT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy_o && (|req_i)) |=> busy_o); // R8
  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy_o) |=> ((gnt_o & ~$past(req_i)) == '0)); // R11
  AST_TAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    busy_o |-> (tier_tail == '0)); // R5
endmodule

// File: tb/test_tiered_chain_arbiter.sv
`timescale 1ns/1ps
module test_tiered_chain_arbiter;
  localparam int NT = 2;
  localparam int CL = 4;
  localparam int N  = NT * CL;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req, done, gnt;
  logic         busy;
  int           total = 0;
  int           bad = 0;
  int           dual_seen = 0;
  bit           finished = 0;

  always #2.5 clk = ~clk;

  tiered_chain_arbiter #(.NUM_TIERS(NT), .CHAIN_LEN(CL)) i_tiered_chain_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done), .gnt_o(gnt), .busy_o(busy)
  );

  // R2 monitor: counts cycles with two owners
  always @(negedge clk) if (rst_n && !$onehot0(gnt)) dual_seen++;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic release_owner(logic [N-1:0] who);
    done = who; step(); done = '0;
    check("R6 grant cleared after done", gnt, '0);
    check("R6 busy low between owners", {7'b0, busy}, '0);
  endtask

  task automatic t_reset();
    req = '0; done = '0; rst_n = 1'b0;
    repeat (3) step();
    check("R1 grant in reset", gnt, '0);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 grant after reset", gnt, '0);
    check("R1 busy after reset", {7'b0, busy}, '0);
  endtask

  task automatic t_single();
    req = 8'b0010_0000; step();
    check("R8 single grant", gnt, 8'b0010_0000);
    check("R9 busy with owner", {7'b0, busy}, 8'd1);
    req = '0;
    release_owner(8'b0010_0000);
  endtask

  task automatic t_chain_order();
    req = 8'b0000_1110; step();
    check("R4 nearest in chain", gnt, 8'b0000_0010);
    req = 8'b0000_1101; step();
    check("R5 no chain preempt", gnt, 8'b0000_0010);
    release_owner(8'b0000_0010);
    step();
    check("R6 rearbitrate pos0", gnt, 8'b0000_0001);
    req = 8'b0000_1100;
    release_owner(8'b0000_0001);
    step();
    check("R4 next pos2", gnt, 8'b0000_0100);
    req = 8'b0000_1000;
    release_owner(8'b0000_0100);
    step();
    check("R4 last pos3", gnt, 8'b0000_1000);
    req = '0;
    release_owner(8'b0000_1000);
  endtask

  task automatic t_tier_order();
    req = 8'b0001_1000; step();
    check("R3 tier0 beats tier1 pos0", gnt, 8'b0000_1000);
    req = 8'b0001_0000;
    release_owner(8'b0000_1000);
    step();
    check("R3 tier1 after tier0", gnt, 8'b0001_0000);
    req = '0;
    release_owner(8'b0001_0000);
  endtask

  task automatic t_no_preempt();
    req = 8'b0100_0000; step();
    check("R11 tier1 owner", gnt, 8'b0100_0000);
    req = 8'b0000_0001; step(); step();
    check("R5 tier0 cannot preempt", gnt, 8'b0100_0000);
    release_owner(8'b0100_0000);
    step();
    check("R5 tier0 after release", gnt, 8'b0000_0001);
    req = '0;
    release_owner(8'b0000_0001);
  endtask

  task automatic t_foreign_done();
    req = 8'b0000_0100; step();
    req = '0;
    done = 8'b1010_1011; step(); done = '0;
    check("R7 foreign done ignored", gnt, 8'b0000_0100);
    step();
    check("R7 still owned", gnt, 8'b0000_0100);
    release_owner(8'b0000_0100);
  endtask

  task automatic t_starve();
    req = 8'b0001_0001;
    for (int i = 0; i < 10; i++) begin
      step();
      check("R10 tier0 keeps bus", gnt, 8'b0000_0001);
      release_owner(8'b0000_0001);
    end
    req = 8'b0001_0000; step();
    check("R10 tier1 served once tier0 quiet", gnt, 8'b0001_0000);
    req = '0;
    release_owner(8'b0001_0000);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_chain_order();
    t_tier_order();
    t_no_preempt();
    t_foreign_done();
    t_starve();
    total++;
    if (dual_seen != 0) begin
      bad++;
      $display("FAIL R2 double grant cycles actual=%0d expected=0", dual_seen);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule